// File: doc/BRIEF.md
# Register Rotate and Shift Unit

This unit performs the single-operand rotate and shift operations of a small 8-bit microcontroller datapath. It takes an 8-bit opcode, the operand the core has already read from a register-file location, and the current carry, sign and zero flags. One clock later it presents the result, which the core writes back to the same register location, together with the new flag values. A one-cycle write strobe marks each executed instruction.

Opcodes 0x30 through 0x36 select seven operations: rotate left, rotate right, rotate left through carry, rotate right through carry, shift left, logical shift right and arithmetic shift right. Every one of these operations updates the carry flag. Sign and zero are carried through unchanged.

Any other opcode that is issued raises an illegal-operation pulse instead of the write strobe. In that case the operand and all incoming flags come back unchanged. When nothing is issued, the registered outputs keep their values.

Top module: `rot_shift_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, every output is 0.
- R2: Opcode 0x30, rotate left: result = {a[6:0], a[7]}; carry out = a[7].
- R3: Opcode 0x31, rotate right: result = {a[0], a[7:1]}; carry out = a[0].
- R4: Opcode 0x32, rotate left through carry: result = {a[6:0], carry in}; carry out = a[7].
- R5: Opcode 0x33, rotate right through carry: result = {carry in, a[7:1]}; carry out = a[0].
- R6: Opcode 0x34, shift left: result = {a[6:0], 0}; carry out = a[7].
- R7: Opcode 0x35, logical shift right: result = {0, a[7:1]}; carry out = a[0].
- R8: Opcode 0x36, arithmetic shift right: result = {a[7], a[7:1]}; carry out = a[0].
- R9: For every issued opcode, sign_o and zero_o equal the sign_in and zero_in presented with it.
- R10: An issued opcode outside 0x30..0x36 gives illegal_o = 1 and wr_en_o = 0. The result equals the operand and carry_o equals carry_in.
- R11: wr_en_o is high for exactly one cycle, the cycle after each issue of a legal opcode, and is low otherwise.
- R12: All outputs are registered and appear one cycle after issue. In a cycle with no issue, result and flags hold their values, and wr_en_o and illegal_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Instruction opcode |
| operand | input | 8 | Value read from the register location |
| carry_in | input | 1 | Current carry flag |
| sign_in | input | 1 | Current sign flag |
| zero_in | input | 1 | Current zero flag |
| result_o | output | 8 | Value to write back to the same register |
| carry_o | output | 1 | New carry flag |
| sign_o | output | 1 | Sign flag, passed through |
| zero_o | output | 1 | Zero flag, passed through |
| wr_en_o | output | 1 | One-cycle write strobe for a legal operation |
| illegal_o | output | 1 | One-cycle pulse for an unsupported opcode |

## Verification
Every output of this unit is due exactly one rising edge after the issue cycle. The bench drives stimulus on the falling edge and compares outputs on the next falling edge, which is half a cycle after the capturing edge. Its reference model stores one set of expectations per issue and keeps them unchanged through idle cycles, so the checks of the hold behaviour follow directly. Each cycle compares all six outputs, including during and right after reset.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  typedef enum logic [2:0] {
    OP_RL   = 3'd0,
    OP_RR   = 3'd1,
    OP_RLC  = 3'd2,
    OP_RRC  = 3'd3,
    OP_SHL  = 3'd4,
    OP_SHR  = 3'd5,
    OP_SAR  = 3'd6,
    OP_NONE = 3'd7
  } rsu_op_e;
endpackage

// File: rtl/rsu_decode.sv
module rsu_decode #(
  parameter int          OPC_W    = 8,
  parameter logic [7:0]  OPC_BASE = 8'h30
) (
  input  logic [OPC_W-1:0] opcode,
  output logic             legal,
  output rsu_pkg::rsu_op_e op
);
  import rsu_pkg::*;
  localparam int SEL_W = 3;

  logic group_hit;
  logic [SEL_W-1:0] sel;

  always_comb begin
    sel       = opcode[SEL_W-1:0];
    group_hit = (opcode[OPC_W-1:SEL_W] == OPC_W'(OPC_BASE) >> SEL_W);
    legal     = group_hit && (sel != {SEL_W{1'b1}});
    op        = legal ? rsu_op_e'(sel) : OP_NONE;
  end

  // R10: a non-group opcode must never decode to an operation
  always_comb begin
    if (!group_hit)
      a_r10_outside_none : assert (op == OP_NONE);
  end
endmodule

// File: rtl/rsu_shift.sv
module rsu_shift #(
  parameter int W = 8
) (
  input  rsu_pkg::rsu_op_e op,
  input  logic [W-1:0]     a,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cout
);
  import rsu_pkg::*;

  logic go_left, go_right;
  logic fill_lsb, fill_msb;
  logic [W-1:0] left_v, right_v;

  always_comb begin
    go_left  = (op == OP_RL) || (op == OP_RLC) || (op == OP_SHL);
    go_right = (op == OP_RR) || (op == OP_RRC) || (op == OP_SHR) || (op == OP_SAR);
    unique case (op)
      OP_RL:   fill_lsb = a[W-1];
      OP_RLC:  fill_lsb = cin;
      default: fill_lsb = 1'b0;
    endcase
    unique case (op)
      OP_RR:   fill_msb = a[0];
      OP_RRC:  fill_msb = cin;
      OP_SAR:  fill_msb = a[W-1];
      default: fill_msb = 1'b0;
    endcase
  end

  for (genvar gi = 0; gi < W; gi++) begin : g_lane
    if (gi == 0) begin : g_lo
      assign left_v[gi] = fill_lsb;
    end else begin : g_lo_n
      assign left_v[gi] = a[gi-1];
    end
    if (gi == W-1) begin : g_hi
      assign right_v[gi] = fill_msb;
    end else begin : g_hi_n
      assign right_v[gi] = a[gi+1];
    end
  end

  always_comb begin
    if (go_left) begin
      res  = left_v;
      cout = a[W-1];
    end else if (go_right) begin
      res  = right_v;
      cout = a[0];
    end else begin
      res  = a;
      cout = cin;
    end
  end

  // R2 R3: plain rotates keep the number of set bits
  always_comb begin
    if (op == OP_RL || op == OP_RR)
      a_r2_rotate_popcount : assert ($countones(res) == $countones(a));
  end
  // R8: arithmetic shift keeps the top bit
  always_comb begin
    if (op == OP_SAR)
      a_r8_sar_top_kept : assert (res[W-1] == a[W-1]);
  end
endmodule

// File: rtl/rot_shift_unit.sv
module rot_shift_unit #(
  parameter int         W        = 8,
  parameter int         OPC_W    = 8,
  parameter logic [7:0] OPC_BASE = 8'h30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_valid,
  input  logic [OPC_W-1:0] opcode,
  input  logic [W-1:0]     operand,
  input  logic             carry_in,
  input  logic             sign_in,
  input  logic             zero_in,
  output logic [W-1:0]     result_o,
  output logic             carry_o,
  output logic             sign_o,
  output logic             zero_o,
  output logic             wr_en_o,
  output logic             illegal_o
);
  import rsu_pkg::*;

  logic     legal;
  rsu_op_e  op;
  logic [W-1:0] res;
  logic     cout;

  rsu_decode #(.OPC_W(OPC_W), .OPC_BASE(OPC_BASE)) u_dec (
    .opcode (opcode),
    .legal  (legal),
    .op     (op)
  );

  rsu_shift #(.W(W)) u_sh (
    .op   (op),
    .a    (operand),
    .cin  (carry_in),
    .res  (res),
    .cout (cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      carry_o   <= 1'b0;
      sign_o    <= 1'b0;
      zero_o    <= 1'b0;
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      wr_en_o   <= issue_valid & legal;
      illegal_o <= issue_valid & ~legal;
      if (issue_valid) begin
        result_o <= res;
        carry_o  <= cout;
        sign_o   <= sign_in;
        zero_o   <= zero_in;
      end
    end
  end

  a_r10_no_write_on_illegal : assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !wr_en_o);
  a_r11_we_needs_issue : assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> $past(issue_valid));
  a_r11_we_single_pulse : assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && !issue_valid) |=> !wr_en_o);
  a_r9_flags_follow : assert property (@(posedge clk) disable iff (rst)
    (wr_en_o || illegal_o) |-> (sign_o == $past(sign_in) && zero_o == $past(zero_in)));
  a_r12_hold_when_idle : assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> ($stable(result_o) && $stable(carry_o) && !wr_en_o && !illegal_o));
  a_r10_illegal_passes : assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (result_o == $past(operand) && carry_o == $past(carry_in)));
endmodule

// File: tb/rot_shift_unit_test.sv
`timescale 1ns/1ps
module rot_shift_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue_valid = 1'b0;
  logic [7:0] opcode = '0, operand = '0;
  logic carry_in = 1'b0, sign_in = 1'b0, zero_in = 1'b0;
  logic [7:0] result_o;
  logic carry_o, sign_o, zero_o, wr_en_o, illegal_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  int exp_res = 0, exp_c = 0, exp_s = 0, exp_z = 0, exp_we = 0, exp_ill = 0;
  string exp_tag = "R1";

  always #2.5 clk = ~clk;

  rot_shift_unit uut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .opcode(opcode),
    .operand(operand), .carry_in(carry_in), .sign_in(sign_in), .zero_in(zero_in),
    .result_o(result_o), .carry_o(carry_o), .sign_o(sign_o), .zero_o(zero_o),
    .wr_en_o(wr_en_o), .illegal_o(illegal_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string flag_tag, string ctl_tag);
    chk(exp_tag, "result", int'(result_o), exp_res);
    chk(exp_tag, "carry", int'(carry_o), exp_c);
    chk(flag_tag, "sign", int'(sign_o), exp_s);
    chk(flag_tag, "zero", int'(zero_o), exp_z);
    chk(ctl_tag, "wr_en", int'(wr_en_o), exp_we);
    chk(ctl_tag, "illegal", int'(illegal_o), exp_ill);
  endtask

  // behavioural reference; updates expectation for the next cycle
  task automatic model(bit v, int opc, int a, int c, int s, int z);
    int r, co;
    string t;
    exp_we = 0;
    exp_ill = 0;
    if (!v) begin
      exp_tag = "R12";
      return;
    end
    r = a; co = c; t = "R10";
    case (opc)
      'h30: begin r = ((a * 2) % 256) + (a / 128); co = a / 128; t = "R2"; end
      'h31: begin r = (a / 2) + (a % 2) * 128;      co = a % 2;   t = "R3"; end
      'h32: begin r = ((a * 2) % 256) + c;          co = a / 128; t = "R4"; end
      'h33: begin r = (a / 2) + c * 128;            co = a % 2;   t = "R5"; end
      'h34: begin r = (a * 2) % 256;                co = a / 128; t = "R6"; end
      'h35: begin r = a / 2;                        co = a % 2;   t = "R7"; end
      'h36: begin r = (a / 2) + (a / 128) * 128;    co = a % 2;   t = "R8"; end
      default: ;
    endcase
    exp_tag = t;
    exp_res = r;
    exp_c = co;
    exp_s = s;
    exp_z = z;
    if (t == "R10") exp_ill = 1; else exp_we = 1;
  endtask

  task automatic step(bit v, int opc, int a, int c, int s, int z);
    @(negedge clk);
    check_all("R9", (exp_tag == "R10") ? "R10" : ((exp_tag == "R12") ? "R12" : "R11"));
    issue_valid = v;
    opcode = 8'(opc);
    operand = 8'(a);
    carry_in = c[0];
    sign_in = s[0];
    zero_in = z[0];
    model(v, opc, a, c, s, z);
  endtask

  initial begin
    int pats[6] = '{'h81, 'h01, 'h80, 'h55, 'hFF, 'h00};
    int bad[5] = '{'h37, 'h2F, 'h00, 'h38, 'hB0};
    // R1: reset state, with an issue held during reset
    issue_valid = 1'b1; opcode = 8'h30; operand = 8'hFF; carry_in = 1'b1;
    sign_in = 1'b1; zero_in = 1'b1;
    repeat (3) begin
      @(negedge clk);
      exp_tag = "R1";
      check_all("R1", "R1");
    end
    issue_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    model(0, 0, 0, 0, 0, 0);
    exp_tag = "R1";
    // every opcode, every pattern, both carries
    for (int op = 'h30; op <= 'h36; op++)
      for (int p = 0; p < 6; p++)
        for (int c = 0; c < 2; c++)
          step(1, op, pats[p], c, p % 2, c);
    // R10: unsupported opcodes
    for (int b = 0; b < 5; b++) step(1, bad[b], 'hA5 + b, b % 2, 1, b % 2);
    // R12: idle cycles hold result
    step(1, 'h36, 'h92, 0, 1, 0);
    step(0, 'h30, 'h11, 1, 0, 1);
    step(0, 'h31, 'h22, 0, 1, 1);
    // R11: back-to-back issues
    step(1, 'h32, 'h7E, 1, 0, 0);
    step(1, 'h33, 'h7E, 1, 1, 1);
    // mixed stream
    for (int i = 0; i < 2000; i++) begin
      int v = ($urandom % 4) != 0;
      int opc = ($urandom % 3 == 0) ? int'($urandom % 256) : int'('h30 + $urandom % 7);
      step(v[0], opc, int'($urandom % 256), int'($urandom % 2),
           int'($urandom % 2), int'($urandom % 2));
    end
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule